// File: doc/BRIEF.md
# Shared-Memory Profile Switcher

This block sits between three processor cores and the single data memory they share. Only one core runs at a time. A small selection register, placed at the all-ones address of the common data address space, holds one bit per core, and the bit that is set marks the core that runs. The cores do not hand control to each other directly. The running core stores a new one-hot word to the all-ones address, and on the next clock edge the block stalls that core and releases the chosen one. Each core keeps its own private instruction memory, which is outside this block.

Each cycle the block takes the memory request of the running core and drops the requests of the stalled cores. A request to an ordinary address goes to the shared memory port unchanged. A request to the all-ones address is handled by the selection register and never reaches memory. The shared memory is assumed to return read data one cycle after a request. A read of the selection register follows the same one-cycle timing, so a core sees the same read latency at every address.

Top module: `profile_switch`

## Requirements
- R1: While reset is asserted, and right after it, `runEn` is 3'b001: the first core runs and the other two are stalled. Bit i of `runEn` is core i.
- R2: When the running core requests an address other than all-ones, `dmReq` is high in the same cycle, and `dmAddr`, `dmWe` and `dmWdata` equal that core's address, write flag and write data.
- R3: A request from a stalled core never asserts `dmReq` and never changes `runEn`, even when it writes the all-ones address.
- R4: When the running core writes a legal word to the all-ones address, `runEn` takes the low three bits of that word on the next clock edge. A legal word has bits 31..3 all zero and exactly one of bits 2..0 set.
- R5: An access to the all-ones address never asserts `dmReq`.
- R6: A write of an illegal word to the all-ones address leaves `runEn` unchanged. Illegal means zero bits set, two or more bits set, or any bit above bit 2 set.
- R7: One cycle after the running core reads the all-ones address, `coreRdata` equals `runEn` zero-extended to 32 bits. After any other read, `coreRdata` passes `dmRdata` through.
- R8: A word stored by one core before it hands over control can be read back by the next core at the same address, because all cores share one data space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coreReq | input | 3 | Memory request valid, one bit per core |
| coreWe | input | 3 | Write flag, one bit per core |
| coreAddr | input | 3x32 | Byte-free word address, one per core |
| coreWdata | input | 3x32 | Write data, one per core |
| coreRdata | output | 32 | Read data returned to the running core, one cycle after its read |
| runEn | output | 3 | One-hot run enable; a low bit stalls that core |
| dmReq | output | 1 | Shared memory request |
| dmWe | output | 1 | Shared memory write flag |
| dmAddr | output | 32 | Shared memory address |
| dmWdata | output | 32 | Shared memory write data |
| dmRdata | input | 32 | Shared memory read data, valid one cycle after a read request |

## Verification
The bench goes after the handover itself. Core 0 stores a word and then selects core 1, and core 1 must read that word back. A design that switched one edge too early, or leaked the control write into memory, breaks this read or the `dmReq` check on the switching cycle. Stalled cores write ordinary addresses and then the control address. A design that merged requests from all cores would overwrite memory or change the selection, and the next read or `runEn` shows it. The illegal words used are zero, two bits set, a single bit above bit 2, and a high bit together with a legal low bit. A design that only checks the low bits, or counts bits without checking the upper field, would switch cores on one of them.

// File: rtl/psw_pkg.sv
package psw_pkg;
  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic fwd;     // forward the selected request to the shared memory
    logic ctrlRd;  // the selected request reads the selection register
  } pswStrobe_t;
endpackage

// File: rtl/psw_ctrl.sv
module psw_ctrl
  import psw_pkg::*;
#(
  parameter int NUM_PROF = 3,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                selReq,
  input  logic                selWe,
  input  logic [AW-1:0]       selAddr,
  input  logic [DW-1:0]       selWdata,
  output pswStrobe_t          strobe,
  output logic [NUM_PROF-1:0] profSel
);
  localparam logic [AW-1:0]       CTRL_ADDR = {AW{1'b1}};
  localparam logic [NUM_PROF-1:0] RESET_SEL = NUM_PROF'(1);

  logic ctrlHit;
  logic ctrlWr;
  logic legal;

  always_comb begin
    ctrlHit       = (selAddr == CTRL_ADDR);
    strobe.fwd    = selReq && !ctrlHit;
    strobe.ctrlRd = selReq && ctrlHit && !selWe;
    ctrlWr        = selReq && ctrlHit && selWe;
    legal         = (selWdata[DW-1:NUM_PROF] == '0) &&
                    ($countones(selWdata[NUM_PROF-1:0]) == 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      profSel <= RESET_SEL;
    end else if (ctrlWr && legal) begin
      profSel <= selWdata[NUM_PROF-1:0];
    end
  end
endmodule

// File: rtl/psw_datapath.sv
module psw_datapath
  import psw_pkg::*;
#(
  parameter int NUM_PROF = 3,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_PROF-1:0]          grant,
  input  pswStrobe_t                   strobe,
  input  logic [NUM_PROF-1:0]          coreReq,
  input  logic [NUM_PROF-1:0]          coreWe,
  input  logic [NUM_PROF-1:0][AW-1:0]  coreAddr,
  input  logic [NUM_PROF-1:0][DW-1:0]  coreWdata,
  output logic                         selReq,
  output logic                         selWe,
  output logic [AW-1:0]                selAddr,
  output logic [DW-1:0]                selWdata,
  output logic                         dmReq,
  output logic                         dmWe,
  output logic [AW-1:0]                dmAddr,
  output logic [DW-1:0]                dmWdata,
  input  logic [DW-1:0]                dmRdata,
  output logic [DW-1:0]                coreRdata
);
  localparam int PAD = DW - NUM_PROF;

  logic          rdCtrlQ;
  logic [DW-1:0] rdValQ;

  // AND-OR mux over the one-hot grant
  always_comb begin
    selReq   = 1'b0;
    selWe    = 1'b0;
    selAddr  = '0;
    selWdata = '0;
    for (int i = 0; i < NUM_PROF; i++) begin
      selReq   = selReq | (coreReq[i] & grant[i]);
      selWe    = selWe | (coreWe[i] & grant[i]);
      selAddr  = selAddr | ({AW{grant[i]}} & coreAddr[i]);
      selWdata = selWdata | ({DW{grant[i]}} & coreWdata[i]);
    end
  end

  always_comb begin
    dmReq   = strobe.fwd;
    dmWe    = strobe.fwd & selWe;
    dmAddr  = selAddr;
    dmWdata = selWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdCtrlQ <= 1'b0;
      rdValQ  <= '0;
    end else begin
      rdCtrlQ <= strobe.ctrlRd;
      rdValQ  <= {{PAD{1'b0}}, grant};
    end
  end

  assign coreRdata = rdCtrlQ ? rdValQ : dmRdata;
endmodule

// File: rtl/profile_switch.sv
module profile_switch
  import psw_pkg::*;
#(
  parameter int NUM_PROF = 3,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_PROF-1:0]          coreReq,
  input  logic [NUM_PROF-1:0]          coreWe,
  input  logic [NUM_PROF-1:0][AW-1:0]  coreAddr,
  input  logic [NUM_PROF-1:0][DW-1:0]  coreWdata,
  output logic [DW-1:0]                coreRdata,
  output logic [NUM_PROF-1:0]          runEn,
  output logic                         dmReq,
  output logic                         dmWe,
  output logic [AW-1:0]                dmAddr,
  output logic [DW-1:0]                dmWdata,
  input  logic [DW-1:0]                dmRdata
);
  pswStrobe_t          strobe;
  logic                selReq;
  logic                selWe;
  logic [AW-1:0]       selAddr;
  logic [DW-1:0]       selWdata;
  logic [NUM_PROF-1:0] profSel;

  psw_ctrl #(.NUM_PROF(NUM_PROF), .AW(AW), .DW(DW)) uCtrl (
    .clk(clk), .rstN(rstN),
    .selReq(selReq), .selWe(selWe), .selAddr(selAddr), .selWdata(selWdata),
    .strobe(strobe), .profSel(profSel)
  );

  psw_datapath #(.NUM_PROF(NUM_PROF), .AW(AW), .DW(DW)) uDp (
    .clk(clk), .rstN(rstN), .grant(profSel), .strobe(strobe),
    .coreReq(coreReq), .coreWe(coreWe), .coreAddr(coreAddr), .coreWdata(coreWdata),
    .selReq(selReq), .selWe(selWe), .selAddr(selAddr), .selWdata(selWdata),
    .dmReq(dmReq), .dmWe(dmWe), .dmAddr(dmAddr), .dmWdata(dmWdata),
    .dmRdata(dmRdata), .coreRdata(coreRdata)
  );

  assign runEn = profSel;
endmodule

// File: rtl/profile_switch_chk.sv
module profile_switch_chk #(
  parameter int NUM_PROF = 3,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NUM_PROF-1:0]          coreReq,
  input logic [NUM_PROF-1:0]          coreWe,
  input logic [NUM_PROF-1:0][AW-1:0]  coreAddr,
  input logic [NUM_PROF-1:0][DW-1:0]  coreWdata,
  input logic [DW-1:0]                coreRdata,
  input logic [NUM_PROF-1:0]          runEn,
  input logic                         dmReq,
  input logic                         dmWe,
  input logic [AW-1:0]                dmAddr,
  input logic [DW-1:0]                dmWdata,
  input logic [DW-1:0]                dmRdata
);
  localparam logic [AW-1:0] ALL_ONES = {AW{1'b1}};

  logic          actReq;
  logic          actWe;
  logic [AW-1:0] actAddr;
  logic [DW-1:0] actWdata;
  logic          actLegal;

  always_comb begin
    actReq   = 1'b0;
    actWe    = 1'b0;
    actAddr  = '0;
    actWdata = '0;
    for (int i = 0; i < NUM_PROF; i++) begin
      if (runEn[i]) begin
        actReq   = coreReq[i];
        actWe    = coreWe[i];
        actAddr  = coreAddr[i];
        actWdata = coreWdata[i];
      end
    end
    actLegal = (actWdata[DW-1:NUM_PROF] == '0) &&
               ($countones(actWdata[NUM_PROF-1:0]) == 1);
  end

  assert_single_profile_R4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(runEn) == 1);

  assert_forward_R2: assert property (@(posedge clk) disable iff (!rstN)
    (actReq && actAddr != ALL_ONES) |->
      (dmReq && dmAddr == actAddr && dmWe == actWe && dmWdata == actWdata));

  assert_stalled_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    dmReq |-> ((coreReq & runEn) != '0));

  assert_ctrl_absorbed_R5: assert property (@(posedge clk) disable iff (!rstN)
    dmReq |-> (dmAddr != ALL_ONES));

  assert_illegal_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (actReq && actWe && actAddr == ALL_ONES && !actLegal) |=> $stable(runEn));

  assert_ctrl_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (actReq && !actWe && actAddr == ALL_ONES) |=>
      (coreRdata == {{(DW-NUM_PROF){1'b0}}, $past(runEn)}));
endmodule

bind profile_switch profile_switch_chk #(.NUM_PROF(NUM_PROF), .AW(AW), .DW(DW)) uChk (.*);

// File: tb/profile_switch_test.sv
module profile_switch_test;
  typedef struct packed {
    logic [1:0]  core;
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
    logic        expFwd;
    logic [2:0]  expRun;
    logic        chkRd;
    logic [31:0] expRd;
  } vec_t;

  localparam int NV = 16;
  localparam logic [31:0] CA = 32'hFFFF_FFFF;
  localparam vec_t VEC [0:NV-1] = '{
    '{2'd0, 1'b1, 32'h4, 32'hA5,        1'b1, 3'b001, 1'b0, 32'h0},  // core0 store
    '{2'd0, 1'b0, 32'h4, 32'h0,         1'b1, 3'b001, 1'b1, 32'hA5}, // core0 read back
    '{2'd1, 1'b1, 32'h4, 32'h11,        1'b0, 3'b001, 1'b0, 32'h0},  // stalled store
    '{2'd0, 1'b0, 32'h4, 32'h0,         1'b1, 3'b001, 1'b1, 32'hA5}, // unchanged
    '{2'd0, 1'b0, CA,    32'h0,         1'b0, 3'b001, 1'b1, 32'h1},  // ctrl read
    '{2'd0, 1'b1, CA,    32'h2,         1'b0, 3'b010, 1'b0, 32'h0},  // hand to core1
    '{2'd1, 1'b0, 32'h4, 32'h0,         1'b1, 3'b010, 1'b1, 32'hA5}, // core1 sees store
    '{2'd1, 1'b1, CA,    32'h3,         1'b0, 3'b010, 1'b0, 32'h0},  // two bits
    '{2'd1, 1'b1, CA,    32'h0,         1'b0, 3'b010, 1'b0, 32'h0},  // zero
    '{2'd1, 1'b1, CA,    32'h8,         1'b0, 3'b010, 1'b0, 32'h0},  // bit out of range
    '{2'd1, 1'b1, CA,    32'h8000_0001, 1'b0, 3'b010, 1'b0, 32'h0},  // high bit set
    '{2'd2, 1'b1, CA,    32'h1,         1'b0, 3'b010, 1'b0, 32'h0},  // stalled ctrl write
    '{2'd1, 1'b1, CA,    32'h4,         1'b0, 3'b100, 1'b0, 32'h0},  // hand to core2
    '{2'd2, 1'b1, 32'h7, 32'h77,        1'b1, 3'b100, 1'b0, 32'h0},
    '{2'd2, 1'b0, CA,    32'h0,         1'b0, 3'b100, 1'b1, 32'h4},
    '{2'd2, 1'b0, 32'h7, 32'h0,         1'b1, 3'b100, 1'b1, 32'h77}
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic [2:0]        coreReq;
  logic [2:0]        coreWe;
  logic [2:0][31:0]  coreAddr;
  logic [2:0][31:0]  coreWdata;
  logic [31:0]       coreRdata;
  logic [2:0]        runEn;
  logic              dmReq;
  logic              dmWe;
  logic [31:0]       dmAddr;
  logic [31:0]       dmWdata;
  logic [31:0]       dmRdata;
  logic [31:0]       mem [0:15];

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  profile_switch uut (.*);

  // shared memory model, one-cycle read latency
  always_ff @(posedge clk) begin
    if (dmReq) begin
      if (dmWe) mem[dmAddr[3:0]] <= dmWdata;
      dmRdata <= mem[dmAddr[3:0]];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    coreReq = '0; coreWe = '0; coreAddr = '0; coreWdata = '0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    dmRdata = '0;
    idle();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(runEn == 3'b001, "R1 reset selection", {29'b0, runEn}, 32'h1);
    rstN = 1'b1;
    @(negedge clk);
    chk(runEn == 3'b001, "R1 after reset", {29'b0, runEn}, 32'h1);

    for (int v = 0; v < NV; v++) begin
      coreReq[VEC[v].core]   = 1'b1;
      coreWe[VEC[v].core]    = VEC[v].we;
      coreAddr[VEC[v].core]  = VEC[v].addr;
      coreWdata[VEC[v].core] = VEC[v].data;
      #1;
      chk(dmReq == VEC[v].expFwd, "R2/R3/R5 forward decision",
          {31'b0, dmReq}, {31'b0, VEC[v].expFwd});
      if (VEC[v].expFwd) begin
        chk(dmAddr == VEC[v].addr && dmWe == VEC[v].we &&
            (!VEC[v].we || dmWdata == VEC[v].data),
            "R2 forwarded fields", dmAddr, VEC[v].addr);
      end
      @(negedge clk);
      idle();
      chk(runEn == VEC[v].expRun, "R4/R6 selection", {29'b0, runEn},
          {29'b0, VEC[v].expRun});
      if (VEC[v].chkRd) begin
        chk(coreRdata == VEC[v].expRd, "R7/R8 read data", coreRdata, VEC[v].expRd);
      end
    end

    // directed: stalled core writes plain memory, then running core reads it
    coreReq[0] = 1'b1; coreWe[0] = 1'b1; coreAddr[0] = 32'h7; coreWdata[0] = 32'hDEAD;
    #1;
    chk(dmReq == 1'b0, "R3 stalled store dropped", {31'b0, dmReq}, 32'h0);
    @(negedge clk);
    idle();
    coreReq[2] = 1'b1; coreAddr[2] = 32'h7;
    @(negedge clk);
    idle();
    chk(coreRdata == 32'h77, "R3 memory untouched", coreRdata, 32'h77);

    // directed: reset mid-run returns to the first core
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk(runEn == 3'b001, "R1 reset mid-run", {29'b0, runEn}, 32'h1);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule